// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block decides which analog input an ADC converts next and when each conversion begins. Software programs a set of channels in one of two ways: as a 20-bit enable mask, where each set bit is one input, or as an ordered list of up to eight channel numbers. Mask mode can walk the enabled inputs upward or downward. List mode always walks its slots in the order they were written.

A sequence starts either from a software start pulse or from an edge on one of eight hardware trigger inputs. A hardware trigger can be set to fire on the rising edge, the falling edge or both. Three run modes are available:
- Single mode converts the whole set once for each start.
- Continuous mode repeats the set until the mode is cleared.
- Discontinuous mode converts one channel for each start.

For each conversion the block drives a channel number together with a one-cycle start pulse, then waits for the converter's end-of-conversion strobe. It marks the last conversion of a set with an end-of-sequence pulse. A configuration-ready flag guards changes to the channel setup.

Top module: `adc_scan_seq`

## Requirements
- R1: After synchronous reset the block is idle, with `conv_start`, `seq_busy`, `seq_eos` and `cfg_err` all low and `cfg_ready` high. The stored mask is empty, the list holds only terminators, and the mode is mask mode scanning upward.
- R2: In mask mode with `mode_down`=0, the enabled channels are converted in rising channel order (bit i of `sel_mask` enables channel i).
- R3: In mask mode with `mode_down`=1, the enabled channels are converted in falling channel order.
- R4: In list mode, slot k of `sel_list` occupies bits [5k+4:5k] and slots are converted from slot 0 upward.
  - A slot holding 31 ends the list, so it and every later slot are not converted.
  - A slot holding 20 to 30 is skipped.
  - `mode_down` has no effect on the order.
- R5: Either of two events drops `cfg_ready` for exactly 4 cycles: a `sel_wr` write, or a `mode_wr` write that changes the mode or direction. Specifically, `cfg_ready` is low for the 4 cycles after the clock edge that takes the write and is high again on the fifth. A `mode_wr` taken while `cfg_ready` is low is ignored.
- R6: `trig_mode` selects how a sequence starts:
  - 0: only `sw_start` starts a sequence.
  - 1: rising edges of `trig_in[trig_sel]` start a sequence.
  - 2: falling edges of that input start a sequence.
  - 3: both edges start a sequence.
  
  Unselected inputs have no effect. In modes 1 to 3, `sw_start` is ignored. Trigger inputs are synchronized through two flops before edge detection.
- R7: In single mode (`cont`=0, `disc`=0), each start converts the full set once and the block then returns to idle.
- R8: With `cont`=1 and `disc`=0, the set repeats without further starts. When `cont` is low at the end-of-conversion of a set's last channel, the block stops after that set.
- R9: With `disc`=1 and `cont`=0, each start converts one channel and the block waits for the next start. `seq_eos` pulses only after the last channel.
- R10: With both `cont` and `disc` high, the block behaves as in single mode and `cfg_err` is high from the following cycle.
- R11: A start request that arrives while a conversion is being issued or awaited is ignored.
- R12: `conv_start` is a one-cycle pulse. `seq_eos` is a one-cycle pulse in the cycle after the clock edge that takes the `eoc` of a set's last channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Write strobe for channel mask and list |
| sel_mask | input | 20 | Channel enable mask, bit i = channel i |
| sel_list | input | 40 | Eight 5-bit list slots, slot 0 in the low bits |
| mode_wr | input | 1 | Write strobe for selection mode and direction |
| mode_list | input | 1 | 1 = list mode, 0 = mask mode |
| mode_down | input | 1 | 1 = downward mask scan |
| trig_mode | input | 2 | 0 software, 1 rising, 2 falling, 3 both edges |
| trig_sel | input | 3 | Index of the hardware trigger input |
| cont | input | 1 | Continuous mode |
| disc | input | 1 | Discontinuous mode |
| sw_start | input | 1 | Software start pulse |
| trig_in | input | 8 | Asynchronous hardware trigger inputs |
| eoc | input | 1 | End-of-conversion strobe from the converter |
| conv_chan | output | 5 | Channel to convert |
| conv_start | output | 1 | Start-conversion pulse |
| seq_busy | output | 1 | A sequence is in progress |
| seq_eos | output | 1 | End-of-sequence pulse |
| cfg_ready | output | 1 | Channel configuration has settled |
| cfg_err | output | 1 | Continuous and discontinuous both set |

## Verification
The hardest situation to reach is a mode write that lands inside the settling window of an earlier selection write. The ports give no direct view of whether that write was dropped. The stimulus issues a selection write and, on the very next cycle, a mode write that would switch to list mode with a downward scan. It then counts the ready-low cycles and runs a sequence, whose upward mask order shows that the mode write was discarded. A second hard case is a start request arriving while a conversion is outstanding. The bench pulses a start during the wait for end-of-conversion and then confirms that no extra set follows.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_CONV  = 2'd2,
        ST_PAUSE = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        TRG_SW   = 2'd0,
        TRG_RISE = 2'd1,
        TRG_FALL = 2'd2,
        TRG_BOTH = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic list_mode;
        logic dir_down;
    } scan_mode_t;

    localparam scan_mode_t SCAN_RESET = '{list_mode: 1'b0, dir_down: 1'b0};

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
#(
    parameter int N_CH     = 20,
    parameter int LIST_LEN = 8,
    parameter int CH_W     = 5,
    parameter int SETTLE   = 4,
    localparam int CNT_W   = $clog2(SETTLE + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sel_wr,
    input  logic [N_CH-1:0]            sel_mask,
    input  logic [LIST_LEN*CH_W-1:0]   sel_list,
    input  logic                       mode_wr,
    input  scan_mode_t                 mode_in,
    output logic [N_CH-1:0]            mask_q,
    output logic [LIST_LEN*CH_W-1:0]   list_q,
    output scan_mode_t                 mode_q,
    output logic                       ready
);

    logic [CNT_W-1:0] settle_cnt;
    logic             mode_take;
    logic             changed;

    assign ready     = (settle_cnt == '0);
    assign mode_take = mode_wr && ready && (mode_in != mode_q);
    assign changed   = sel_wr || mode_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '0;
            list_q     <= '1;
            mode_q     <= SCAN_RESET;
            settle_cnt <= '0;
        end else begin
            if (sel_wr) begin
                mask_q <= sel_mask;
                list_q <= sel_list;
            end
            if (mode_take) begin
                mode_q <= mode_in;
            end
            if (changed) begin
                settle_cnt <= CNT_W'(SETTLE);
            end else if (settle_cnt != '0) begin
                settle_cnt <= settle_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
#(
    parameter int N_TRG  = 8,
    localparam int SEL_W = $clog2(N_TRG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRG-1:0]  trig_in,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [1:0]        trig_mode,
    input  logic              sw_start,
    output logic              start_req
);

    logic [N_TRG-1:0] sync1_q;
    logic [N_TRG-1:0] sync2_q;
    logic             prev_q;
    logic             cur;
    logic             hw_edge;

    assign cur = sync2_q[trig_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= trig_in;
            sync2_q <= sync1_q;
            prev_q  <= cur;
        end
    end

    always_comb begin
        hw_edge = 1'b0;
        case (trig_mode)
            TRG_RISE: hw_edge = cur && !prev_q;
            TRG_FALL: hw_edge = !cur && prev_q;
            TRG_BOTH: hw_edge = cur != prev_q;
            default:  hw_edge = 1'b0;
        endcase
    end

    assign start_req = (trig_mode == TRG_SW) ? sw_start : hw_edge;

endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick
    import adc_seq_pkg::*;
#(
    parameter int N_CH     = 20,
    parameter int LIST_LEN = 8,
    parameter int CH_W     = 5
) (
    input  logic [N_CH-1:0]           mask,
    input  logic [LIST_LEN*CH_W-1:0]  list,
    input  scan_mode_t                mode,
    input  logic [N_CH-1:0]           pending,
    output logic [N_CH-1:0]           cand,
    output logic [N_CH-1:0]           pick_oh,
    output logic [CH_W-1:0]           pick_chan
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);
    localparam logic [CH_W-1:0] END_MARK = '1;

    logic [LIST_LEN-1:0] slot_ok;
    logic [CH_W-1:0]     pick_idx;
    logic                walk_down;

    // Slots up to the first end marker that name a real channel.
    always_comb begin
        logic stopped;
        stopped = 1'b0;
        slot_ok = '0;
        for (int i = 0; i < LIST_LEN; i++) begin
            if (list[i*CH_W +: CH_W] == END_MARK) begin
                stopped = 1'b1;
            end
            if (!stopped && (list[i*CH_W +: CH_W] <= LAST_CH)) begin
                slot_ok[i] = 1'b1;
            end
        end
    end

    assign cand      = mode.list_mode ? {{(N_CH-LIST_LEN){1'b0}}, slot_ok} : mask;
    assign walk_down = mode.dir_down && !mode.list_mode;

    always_comb begin
        pick_idx = '0;
        pick_oh  = '0;
        if (walk_down) begin
            for (int i = 0; i < N_CH; i++) begin
                if (pending[i]) begin
                    pick_idx   = CH_W'(i);
                    pick_oh    = '0;
                    pick_oh[i] = 1'b1;
                end
            end
        end else begin
            for (int i = N_CH - 1; i >= 0; i--) begin
                if (pending[i]) begin
                    pick_idx   = CH_W'(i);
                    pick_oh    = '0;
                    pick_oh[i] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        pick_chan = pick_idx;
        if (mode.list_mode) begin
            pick_chan = '0;
            for (int i = 0; i < LIST_LEN; i++) begin
                if (pick_idx == CH_W'(i)) begin
                    pick_chan = list[i*CH_W +: CH_W];
                end
            end
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int N_CH     = 20,
    parameter int LIST_LEN = 8,
    parameter int N_TRG    = 8,
    parameter int SETTLE   = 4,
    localparam int CH_W    = $clog2(N_CH),
    localparam int SEL_W   = $clog2(N_TRG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel_wr,
    input  logic [N_CH-1:0]           sel_mask,
    input  logic [LIST_LEN*CH_W-1:0]  sel_list,
    input  logic                      mode_wr,
    input  logic                      mode_list,
    input  logic                      mode_down,
    input  logic [1:0]                trig_mode,
    input  logic [SEL_W-1:0]          trig_sel,
    input  logic                      cont,
    input  logic                      disc,
    input  logic                      sw_start,
    input  logic [N_TRG-1:0]          trig_in,
    input  logic                      eoc,
    output logic [CH_W-1:0]           conv_chan,
    output logic                      conv_start,
    output logic                      seq_busy,
    output logic                      seq_eos,
    output logic                      cfg_ready,
    output logic                      cfg_err
);

    logic [N_CH-1:0]          mask_q;
    logic [LIST_LEN*CH_W-1:0] list_q;
    scan_mode_t               mode_q;
    scan_mode_t               mode_in;
    logic                     start_req;
    logic [N_CH-1:0]          cand;
    logic [N_CH-1:0]          pick_oh;
    logic [N_CH-1:0]          pending_q;
    logic [N_CH-1:0]          pend_after;
    seq_state_e               state_q;
    logic                     eos_q;
    logic                     err_q;
    logic                     cont_eff;
    logic                     disc_eff;

    assign mode_in = '{list_mode: mode_list, dir_down: mode_down};

    adc_seq_cfg #(
        .N_CH(N_CH), .LIST_LEN(LIST_LEN), .CH_W(CH_W), .SETTLE(SETTLE)
    ) u_cfg (
        .clk(clk), .rst(rst),
        .sel_wr(sel_wr), .sel_mask(sel_mask), .sel_list(sel_list),
        .mode_wr(mode_wr), .mode_in(mode_in),
        .mask_q(mask_q), .list_q(list_q), .mode_q(mode_q),
        .ready(cfg_ready)
    );

    adc_seq_trig #(.N_TRG(N_TRG)) u_trig (
        .clk(clk), .rst(rst),
        .trig_in(trig_in), .trig_sel(trig_sel), .trig_mode(trig_mode),
        .sw_start(sw_start), .start_req(start_req)
    );

    adc_seq_pick #(.N_CH(N_CH), .LIST_LEN(LIST_LEN), .CH_W(CH_W)) u_pick (
        .mask(mask_q), .list(list_q), .mode(mode_q), .pending(pending_q),
        .cand(cand), .pick_oh(pick_oh), .pick_chan(conv_chan)
    );

    // Conflicting run modes fall back to single mode.
    assign cont_eff   = cont && !disc;
    assign disc_eff   = disc && !cont;
    assign pend_after = pending_q & ~pick_oh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
            eos_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            eos_q <= 1'b0;
            err_q <= cont && disc;
            case (state_q)
                ST_IDLE: begin
                    if (start_req && (cand != '0)) begin
                        pending_q <= cand;
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_CONV;
                end
                ST_CONV: begin
                    if (eoc) begin
                        if (pend_after == '0) begin
                            eos_q <= 1'b1;
                            if (cont_eff && (cand != '0)) begin
                                pending_q <= cand;
                                state_q   <= ST_ISSUE;
                            end else begin
                                pending_q <= '0;
                                state_q   <= ST_IDLE;
                            end
                        end else begin
                            pending_q <= pend_after;
                            state_q   <= disc_eff ? ST_PAUSE : ST_ISSUE;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (start_req) begin
                        state_q <= ST_ISSUE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign conv_start = (state_q == ST_ISSUE);
    assign seq_busy   = (state_q != ST_IDLE);
    assign seq_eos    = eos_q;
    assign cfg_err    = err_q;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int N_CH = 20,
    parameter int CH_W = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            sel_wr,
    input logic            cont,
    input logic            disc,
    input logic [CH_W-1:0] conv_chan,
    input logic            conv_start,
    input logic            seq_busy,
    input logic            seq_eos,
    input logic            cfg_ready,
    input logic            cfg_err
);

    p_start_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_eos_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        seq_eos |=> !seq_eos);

    p_conflict_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (cont && disc) |=> cfg_err);

    p_settle_drop_r5: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> !cfg_ready);

    p_chan_range_r4: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (conv_chan < N_CH));

    p_busy_after_start_r11: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> seq_busy);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .cont(cont), .disc(disc),
    .conv_chan(conv_chan), .conv_start(conv_start), .seq_busy(seq_busy),
    .seq_eos(seq_eos), .cfg_ready(cfg_ready), .cfg_err(cfg_err)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_wr = 1'b0;
    logic [19:0] sel_mask = '0;
    logic [39:0] sel_list = '1;
    logic        mode_wr = 1'b0;
    logic        mode_list = 1'b0;
    logic        mode_down = 1'b0;
    logic [1:0]  trig_mode = 2'd0;
    logic [2:0]  trig_sel = 3'd0;
    logic        cont = 1'b0;
    logic        disc = 1'b0;
    logic        sw_start = 1'b0;
    logic [7:0]  trig_in = '0;
    logic        eoc = 1'b0;
    logic [4:0]  conv_chan;
    logic        conv_start;
    logic        seq_busy;
    logic        seq_eos;
    logic        cfg_ready;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk(clk), .rst(rst),
        .sel_wr(sel_wr), .sel_mask(sel_mask), .sel_list(sel_list),
        .mode_wr(mode_wr), .mode_list(mode_list), .mode_down(mode_down),
        .trig_mode(trig_mode), .trig_sel(trig_sel),
        .cont(cont), .disc(disc), .sw_start(sw_start),
        .trig_in(trig_in), .eoc(eoc),
        .conv_chan(conv_chan), .conv_start(conv_start), .seq_busy(seq_busy),
        .seq_eos(seq_eos), .cfg_ready(cfg_ready), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic sel_write(input logic [19:0] m, input int s[8]);
        @(negedge clk);
        sel_wr   = 1'b1;
        sel_mask = m;
        for (int i = 0; i < 8; i++) sel_list[i*5 +: 5] = s[i][4:0];
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic mode_write(input bit lst, input bit dn);
        @(negedge clk);
        mode_wr   = 1'b1;
        mode_list = lst;
        mode_down = dn;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 20 && !cfg_ready; i++) @(negedge clk);
    endtask

    task automatic sw_pulse();
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    // action: 0 none, 1 clear cont once the start is seen, 2 pulse sw_start while waiting
    task automatic expect_conv(input int ch, input bit eos_exp, input string req, input int action);
        bit seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (conv_start) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(seen, req, 0, 1);
        if (seen) begin
            check(conv_chan == 5'(ch), req, int'(conv_chan), ch);
            if (action == 1) cont = 1'b0;
            if (action == 2) begin
                @(negedge clk);
                sw_start = 1'b1;
                @(negedge clk);
                sw_start = 1'b0;
            end
            @(negedge clk);
            eoc = 1'b1;
            @(negedge clk);
            eoc = 1'b0;
            check(seq_eos == eos_exp, {req, " eos"}, int'(seq_eos), int'(eos_exp));
        end
    endtask

    task automatic expect_quiet(input int n, input string req);
        int starts = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_start) starts++;
        end
        check(starts == 0, req, starts, 0);
    endtask

    task automatic t_reset();
        check(conv_start == 1'b0, "R1 conv_start", int'(conv_start), 0);
        check(seq_busy == 1'b0, "R1 busy", int'(seq_busy), 0);
        check(seq_eos == 1'b0, "R1 eos", int'(seq_eos), 0);
        check(cfg_ready == 1'b1, "R1 ready", int'(cfg_ready), 1);
        check(cfg_err == 1'b0, "R1 err", int'(cfg_err), 0);
        sw_pulse();
        expect_quiet(8, "R1 empty mask starts nothing");
    endtask

    task automatic t_scan_up();
        int lst[8] = '{31, 31, 31, 31, 31, 31, 31, 31};
        sel_write(20'h80024, lst);
        wait_ready();
        sw_pulse();
        expect_conv(2, 1'b0, "R2 first", 0);
        expect_conv(5, 1'b0, "R2 second", 0);
        expect_conv(19, 1'b1, "R2 last", 0);
        expect_quiet(10, "R7 idle after single set");
        check(seq_busy == 1'b0, "R7 busy", int'(seq_busy), 0);
    endtask

    task automatic t_settle();
        int lst[8] = '{1, 2, 31, 31, 31, 31, 31, 31};
        @(negedge clk);
        sel_wr   = 1'b1;
        sel_mask = 20'h80024;
        for (int i = 0; i < 8; i++) sel_list[i*5 +: 5] = lst[i][4:0];
        @(negedge clk);
        sel_wr    = 1'b0;
        mode_wr   = 1'b1;
        mode_list = 1'b1;
        mode_down = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check(cfg_ready == 1'b0, "R5 ready low window", int'(cfg_ready), 0);
            @(negedge clk);
            mode_wr = 1'b0;
        end
        check(cfg_ready == 1'b1, "R5 ready back", int'(cfg_ready), 1);
        sw_pulse();
        expect_conv(2, 1'b0, "R5 ignored mode write", 0);
        expect_conv(5, 1'b0, "R5 ignored mode write", 0);
        expect_conv(19, 1'b1, "R5 ignored mode write", 0);
    endtask

    task automatic t_scan_down();
        mode_write(1'b0, 1'b1);
        check(cfg_ready == 1'b0, "R5 mode change drops ready", int'(cfg_ready), 0);
        wait_ready();
        sw_pulse();
        expect_conv(19, 1'b0, "R3 first", 0);
        expect_conv(5, 1'b0, "R3 second", 0);
        expect_conv(2, 1'b1, "R3 last", 0);
    endtask

    task automatic t_list();
        int lst[8] = '{7, 25, 0, 19, 31, 3, 1, 1};
        mode_write(1'b1, 1'b0);
        wait_ready();
        sel_write(20'h00001, lst);
        wait_ready();
        sw_pulse();
        expect_conv(7, 1'b0, "R4 slot0", 0);
        expect_conv(0, 1'b0, "R4 slot2 after skip", 0);
        expect_conv(19, 1'b1, "R4 slot3 then end marker", 0);
        expect_quiet(10, "R4 nothing past end marker");
        mode_write(1'b1, 1'b1);
        wait_ready();
        sw_pulse();
        expect_conv(7, 1'b0, "R4 direction ignored", 0);
        expect_conv(0, 1'b0, "R4 direction ignored", 0);
        expect_conv(19, 1'b1, "R4 direction ignored", 0);
        mode_write(1'b0, 1'b0);
        wait_ready();
    endtask

    task automatic t_triggers();
        int lst[8] = '{31, 31, 31, 31, 31, 31, 31, 31};
        sel_write(20'h00010, lst);
        wait_ready();
        @(negedge clk);
        trig_sel  = 3'd3;
        trig_mode = 2'd1;
        @(negedge clk);
        trig_in[3] = 1'b1;
        expect_conv(4, 1'b1, "R6 rising edge", 0);
        @(negedge clk);
        trig_in[2] = 1'b1;
        expect_quiet(10, "R6 unselected input");
        sw_pulse();
        expect_quiet(10, "R6 sw_start ignored in hw mode");
        trig_mode = 2'd2;
        expect_quiet(6, "R6 mode switch quiet");
        trig_in[3] = 1'b0;
        expect_conv(4, 1'b1, "R6 falling edge", 0);
        @(negedge clk);
        trig_in[3] = 1'b1;
        expect_quiet(10, "R6 rising ignored in falling mode");
        trig_mode = 2'd3;
        @(negedge clk);
        trig_in[3] = 1'b0;
        expect_conv(4, 1'b1, "R6 both: fall", 0);
        @(negedge clk);
        trig_in[3] = 1'b1;
        expect_conv(4, 1'b1, "R6 both: rise", 0);
        trig_mode = 2'd0;
        @(negedge clk);
        trig_in = '0;
        expect_quiet(10, "R6 edges ignored in software mode");
        sw_pulse();
        expect_conv(4, 1'b1, "R6 software start", 0);
    endtask

    task automatic t_continuous();
        int lst[8] = '{31, 31, 31, 31, 31, 31, 31, 31};
        sel_write(20'h00006, lst);
        wait_ready();
        cont = 1'b1;
        sw_pulse();
        expect_conv(1, 1'b0, "R8 pass1", 0);
        expect_conv(2, 1'b1, "R8 pass1 end", 0);
        expect_conv(1, 1'b0, "R8 pass2 no trigger", 0);
        expect_conv(2, 1'b1, "R8 pass2 end", 1);
        expect_quiet(10, "R8 stops after clear");
    endtask

    task automatic t_discontinuous();
        int lst[8] = '{31, 31, 31, 31, 31, 31, 31, 31};
        sel_write(20'h0000E, lst);
        wait_ready();
        disc = 1'b1;
        sw_pulse();
        expect_conv(1, 1'b0, "R9 step1", 0);
        expect_quiet(10, "R9 waits for start");
        sw_pulse();
        expect_conv(2, 1'b0, "R9 step2", 0);
        expect_quiet(10, "R9 waits for start");
        sw_pulse();
        expect_conv(3, 1'b1, "R9 step3 eos", 0);
        expect_quiet(10, "R9 done");
        disc = 1'b0;
    endtask

    task automatic t_conflict();
        cont = 1'b1;
        disc = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(cfg_err == 1'b1, "R10 error flag", int'(cfg_err), 1);
        sw_pulse();
        expect_conv(1, 1'b0, "R10 single behaviour", 0);
        expect_conv(2, 1'b0, "R10 single behaviour", 0);
        expect_conv(3, 1'b1, "R10 single behaviour", 0);
        expect_quiet(10, "R10 no repeat");
        cont = 1'b0;
        disc = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(cfg_err == 1'b0, "R10 flag clears", int'(cfg_err), 0);
    endtask

    task automatic t_busy_ignore();
        int lst[8] = '{31, 31, 31, 31, 31, 31, 31, 31};
        sel_write(20'h00006, lst);
        wait_ready();
        sw_pulse();
        expect_conv(1, 1'b0, "R11 first", 2);
        expect_conv(2, 1'b1, "R11 last", 0);
        expect_quiet(10, "R11 start during conversion ignored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_scan_up();
        t_settle();
        t_scan_down();
        t_list();
        t_triggers();
        t_continuous();
        t_discontinuous();
        t_conflict();
        t_busy_ignore();
        finish_run();
    end

endmodule